// File: doc/BRIEF.md
# Four-Channel Countdown Timer

This peripheral holds four independent down-counters behind one APB slave port. Each channel has its own 64-byte register window and its own interrupt line. Software stores a start value and copies it into the counter with a reload write. It picks single-shot or free-running operation and then enables the channel. When the counter steps from one to zero, the channel's sticky interrupt status bit is set.

Software acknowledges an event by writing 1 to the channel's clear register. An accepted clear starts a fixed guard interval, and during that interval a busy flag reads back and further clear writes are dropped. A per-channel mask gates the status bit onto the interrupt pin. Channel 0's window also holds a read-only word that gathers the status bits of all channels. The APB port has no wait states: reads come straight from the registers and writes take effect at the access-phase clock edge. The port has no ready or error response.

Top module: `quad_apb_downtimer`

## Requirements
- R1: After reset, every channel has counter 0, start value 0, channel disabled, free-running mode, mask set (1), status 0 and busy 0. All interrupt lines are low.
- R2: While enabled (offset 0x10, bit 0 = 1) and nonzero, the counter drops by one on every clock. A disabled channel holds its count. Offset 0x18 reads the current count.
- R3: The step from 1 to 0 is a timeout. It sets the channel's status, which reads at bit 0 of offset 0x20 and at bit n of the channel-0 status word.
- R4: With offset 0x04 bit 0 = 1 (single-shot), the counter stays at 0 after a timeout until the next reload write.
- R5: With offset 0x04 bit 0 = 0 (free-running), a timeout puts the start value (offset 0x08) back into the counter, so events recur every start-value cycles.
- R6: A write of any data to offset 0x14 copies the start value into the counter. This write takes precedence over a decrement in the same cycle. Offset 0x14 reads 0.
- R7: A write with bit 0 = 1 to offset 0x20 while the busy flag is 0 clears the status. A write with bit 0 = 0 changes nothing and starts no busy interval.
- R8: An accepted clear holds the busy flag (offset 0x20 bit 1) at 1 for exactly 4 clocks. Clear writes during that interval are ignored, and a timeout during it still sets the status.
- R9: Interrupt line n is high exactly when channel n's status is 1 and its mask (offset 0x24 bit 0) is 0.
- R10: Offset 0x00 in channel 0's window returns the status of channel n at bit n. Offset 0x00 in the other windows, and any offset with no register, read 0.
- R11: A write to one channel's window changes no other channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for the bus and all counters |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address: bits 7:6 pick the channel, bits 5:0 the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high with pwrite low |
| irq | output | 4 | Per-channel interrupt, status AND NOT mask |

## Verification
A table of stimuli runs each channel with a start value and an enabled interval. The intervals fall below the start value, exactly on it, and across several periods, in both modes. This separates plain decrementing from single-shot stopping and from free-running wrap, and a start value of 1 checks the every-clock wrap. Directed cases then land a timeout inside the clear guard interval, together with a second clear, so a dropped clear can be told apart from a missing timeout. Other directed cases issue a reload on a running channel, send a clear write with data 0, toggle the mask on a pending channel, and read the status word from foreign windows and unused offsets.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

    // register window geometry (byte offsets inside one channel window)
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_STAT   = 6'h00;
    localparam logic [OFF_W-1:0] OFF_MODE   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_LOAD   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_EN     = 6'h10;
    localparam logic [OFF_W-1:0] OFF_RELOAD = 6'h14;
    localparam logic [OFF_W-1:0] OFF_COUNT  = 6'h18;
    localparam logic [OFF_W-1:0] OFF_CLR    = 6'h20;
    localparam logic [OFF_W-1:0] OFF_MASK   = 6'h24;

    typedef enum logic {
        MODE_CONT = 1'b0,
        MODE_ONCE = 1'b1
    } run_mode_e;

endpackage

// File: rtl/qtmr_channel.sv
module qtmr_channel
    import qtmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CLR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] load_o,
    output logic              enable_o,
    output run_mode_e         mode_o,
    output logic              mask_o,
    output logic              status_o,
    output logic              busy_o
);

    localparam int BUSY_W = $clog2(CLR_CYCLES + 1);
    localparam logic [BUSY_W-1:0] BUSY_INIT = BUSY_W'(CLR_CYCLES);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] load;
        logic              enable;
        run_mode_e         mode;
        logic              mask;
        logic              status;
        logic [BUSY_W-1:0] busy_cnt;
    } chan_state_t;

    localparam chan_state_t RST_VAL = '{
        count:    '0,
        load:     '0,
        enable:   1'b0,
        mode:     MODE_CONT,
        mask:     1'b1,
        status:   1'b0,
        busy_cnt: '0
    };

    chan_state_t st_d, st_q;
    logic        expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;

        // counting: the step from one to zero is the timeout event
        if (st_q.enable && (st_q.count != '0)) begin
            if (st_q.count == DATA_W'(1)) begin
                expire_d   = 1'b1;
                st_d.count = (st_q.mode == MODE_CONT) ? st_q.load : '0;
            end else begin
                st_d.count = st_q.count - DATA_W'(1);
            end
        end

        // clear guard interval
        if (st_q.busy_cnt != '0) begin
            st_d.busy_cnt = st_q.busy_cnt - BUSY_W'(1);
        end

        // bus writes; a reload overrides the decrement above
        if (wr_en) begin
            case (wr_off)
                OFF_MODE:   st_d.mode   = run_mode_e'(wr_data[0]);
                OFF_LOAD:   st_d.load   = wr_data;
                OFF_EN:     st_d.enable = wr_data[0];
                OFF_RELOAD: st_d.count  = st_q.load;
                OFF_CLR: begin
                    if (wr_data[0] && (st_q.busy_cnt == '0)) begin
                        st_d.status   = 1'b0;
                        st_d.busy_cnt = BUSY_INIT;
                    end
                end
                OFF_MASK:   st_d.mask   = wr_data[0];
                default: ;
            endcase
        end

        // a timeout always wins over a clear in the same cycle
        if (expire_d) begin
            st_d.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign load_o   = st_q.load;
    assign enable_o = st_q.enable;
    assign mode_o   = st_q.mode;
    assign mask_o   = st_q.mask;
    assign status_o = st_q.status;
    assign busy_o   = (st_q.busy_cnt != '0);

endmodule

// File: rtl/qtmr_rdmux.sv
module qtmr_rdmux
    import qtmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [OFF_W-1:0]           rd_off,
    input  logic [NCH-1:0][DATA_W-1:0] count_i,
    input  logic [NCH-1:0][DATA_W-1:0] load_i,
    input  logic [NCH-1:0]             enable_i,
    input  logic [NCH-1:0]             single_i,
    input  logic [NCH-1:0]             mask_i,
    input  logic [NCH-1:0]             status_i,
    input  logic [NCH-1:0]             busy_i,
    output logic [DATA_W-1:0]          rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            case (rd_off)
                OFF_STAT: begin
                    if (rd_idx == '0) begin
                        rdata_o = DATA_W'(status_i);
                    end
                end
                OFF_MODE:  rdata_o[0]   = single_i[rd_idx];
                OFF_LOAD:  rdata_o      = load_i[rd_idx];
                OFF_EN:    rdata_o[0]   = enable_i[rd_idx];
                OFF_COUNT: rdata_o      = count_i[rd_idx];
                OFF_CLR:   rdata_o[1:0] = {busy_i[rd_idx], status_i[rd_idx]};
                OFF_MASK:  rdata_o[0]   = mask_i[rd_idx];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/quad_apb_downtimer.sv
module quad_apb_downtimer
    import qtmr_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DATA_W     = 32,
    parameter int CLR_CYCLES = 4,
    localparam int IDX_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W    = OFF_W + IDX_W
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NCH-1:0]    irq
);

    logic                       wr_strobe;
    logic                       rd_en;
    logic [IDX_W-1:0]           win_idx;
    logic [OFF_W-1:0]           win_off;

    logic [NCH-1:0][DATA_W-1:0] ch_count;
    logic [NCH-1:0][DATA_W-1:0] ch_load;
    logic [NCH-1:0]             ch_enable;
    logic [NCH-1:0]             ch_single;
    logic [NCH-1:0]             ch_mask;
    logic [NCH-1:0]             ch_status;
    logic [NCH-1:0]             ch_busy;

    assign wr_strobe = psel && penable && pwrite;
    assign rd_en     = psel && !pwrite;
    assign win_idx   = paddr[ADDR_W-1:OFF_W];
    assign win_off   = paddr[OFF_W-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        run_mode_e ch_mode;

        qtmr_channel #(
            .DATA_W     (DATA_W),
            .CLR_CYCLES (CLR_CYCLES)
        ) u_chan (
            .clk      (pclk),
            .rst_n    (presetn),
            .wr_en    (wr_strobe && (win_idx == IDX_W'(g))),
            .wr_off   (win_off),
            .wr_data  (pwdata),
            .count_o  (ch_count[g]),
            .load_o   (ch_load[g]),
            .enable_o (ch_enable[g]),
            .mode_o   (ch_mode),
            .mask_o   (ch_mask[g]),
            .status_o (ch_status[g]),
            .busy_o   (ch_busy[g])
        );

        assign ch_single[g] = (ch_mode == MODE_ONCE);
    end

    qtmr_rdmux #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rdmux (
        .rd_en    (rd_en),
        .rd_idx   (win_idx),
        .rd_off   (win_off),
        .count_i  (ch_count),
        .load_i   (ch_load),
        .enable_i (ch_enable),
        .single_i (ch_single),
        .mask_i   (ch_mask),
        .status_i (ch_status),
        .busy_i   (ch_busy),
        .rdata_o  (prdata)
    );

    assign irq = ch_status & ~ch_mask;

endmodule

// File: rtl/qtmr_checker.sv
module qtmr_checker
    import qtmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       psel,
    input logic                       pwrite,
    input logic                       wr_strobe,
    input logic [IDX_W-1:0]           win_idx,
    input logic [OFF_W-1:0]           win_off,
    input logic [DATA_W-1:0]          pwdata,
    input logic [DATA_W-1:0]          prdata,
    input logic [NCH-1:0][DATA_W-1:0] ch_count,
    input logic [NCH-1:0]             ch_enable,
    input logic [NCH-1:0]             ch_single,
    input logic [NCH-1:0]             ch_status,
    input logic [NCH-1:0]             ch_busy
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic hit;
        logic tmo;
        assign hit = wr_strobe && (win_idx == IDX_W'(g));
        assign tmo = ch_enable[g] && (ch_count[g] == DATA_W'(1));

        a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_enable[g] && (ch_count[g] > DATA_W'(1)) && !(hit && win_off == OFF_RELOAD))
            |=> (ch_count[g] == $past(ch_count[g]) - DATA_W'(1)));

        a_r4_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_single[g] && (ch_count[g] == '0) && !(hit && win_off == OFF_RELOAD))
            |=> (ch_count[g] == '0));

        a_r3_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
            tmo |=> ch_status[g]);

        a_r8_busy_guard: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[g] && ch_busy[g]) |=> ch_status[g]);

        a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && win_off == OFF_CLR && pwdata[0] && !ch_busy[g] && !tmo)
            |=> (!ch_status[g] && ch_busy[g]));
    end

    a_r10_foreign_status: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && (win_idx != '0) && (win_off == OFF_STAT)) |-> (prdata == '0));

endmodule

bind quad_apb_downtimer qtmr_checker #(
    .NCH    (NCH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_qtmr_checker (
    .clk       (pclk),
    .rst_n     (presetn),
    .psel      (psel),
    .pwrite    (pwrite),
    .wr_strobe (wr_strobe),
    .win_idx   (win_idx),
    .win_off   (win_off),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .ch_count  (ch_count),
    .ch_enable (ch_enable),
    .ch_single (ch_single),
    .ch_status (ch_status),
    .ch_busy   (ch_busy)
);

// File: tb/tb_quad_apb_downtimer.sv
module tb_quad_apb_downtimer;

    localparam int CLK_NS = 10;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    quad_apb_downtimer dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq)
    );

    always #(CLK_NS / 2) pclk = ~pclk;

    localparam logic [5:0] R_STAT = 6'h00, R_MODE = 6'h04, R_LOAD = 6'h08, R_EN = 6'h10;
    localparam logic [5:0] R_RLD = 6'h14, R_CNT = 6'h18, R_CLR = 6'h20, R_MASK = 6'h24;

    // ch, start value, single-shot, idle cycles, expected count, expected status
    // enabled interval is idle + 3 clocks
    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] start;
        logic        once;
        logic [7:0]  idle;
        logic [31:0] exp_cnt;
        logic        exp_st;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 32'd20,  1'b0, 8'd2,  32'd15, 1'b0},
        '{2'd1, 32'd5,   1'b1, 8'd4,  32'd0,  1'b1},
        '{2'd2, 32'd4,   1'b0, 8'd7,  32'd2,  1'b1},
        '{2'd3, 32'd6,   1'b0, 8'd3,  32'd6,  1'b1},
        '{2'd0, 32'd3,   1'b1, 8'd0,  32'd0,  1'b1},
        '{2'd1, 32'd100, 1'b0, 8'd10, 32'd87, 1'b0},
        '{2'd2, 32'd1,   1'b0, 8'd1,  32'd1,  1'b1},
        '{2'd3, 32'd8,   1'b1, 8'd1,  32'd4,  1'b0}
    };

    function automatic logic [7:0] ad(input int ch, input logic [5:0] off);
        return {ch[1:0], off};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge pclk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R1 reset state
        check("R1 irq", {28'd0, irq}, 32'd0);
        apb_rd(ad(0, R_STAT), v); check("R1 status word", v, 32'd0);
        for (int c = 0; c < 4; c++) begin
            apb_rd(ad(c, R_CNT), v);  check("R1 count", v, 32'd0);
            apb_rd(ad(c, R_LOAD), v); check("R1 start value", v, 32'd0);
            apb_rd(ad(c, R_MODE), v); check("R1 mode", v, 32'd0);
            apb_rd(ad(c, R_EN), v);   check("R1 enable", v, 32'd0);
            apb_rd(ad(c, R_MASK), v); check("R1 mask", v, 32'd1);
            apb_rd(ad(c, R_CLR), v);  check("R1 clear reg", v, 32'd0);
        end

        // table: R2 decrement, R3 timeout, R4 single-shot, R5 free-running
        for (int i = 0; i < 8; i++) begin
            int c;
            c = int'(VECS[i].ch);
            apb_wr(ad(c, R_CLR), 32'd1);
            apb_wr(ad(c, R_MODE), {31'd0, VECS[i].once});
            apb_wr(ad(c, R_LOAD), VECS[i].start);
            apb_wr(ad(c, R_RLD), i[0] ? 32'hFFFF_FFFF : 32'd0);
            apb_wr(ad(c, R_EN), 32'd1);
            repeat (int'(VECS[i].idle)) @(negedge pclk);
            apb_wr(ad(c, R_EN), 32'd0);
            apb_rd(ad(c, R_CNT), v);
            check(VECS[i].once ? "R4 R2 count" : "R5 R2 count", v, VECS[i].exp_cnt);
            apb_rd(ad(c, R_CLR), v);
            check("R3 channel status", v, {31'd0, VECS[i].exp_st});
            apb_rd(ad(0, R_STAT), v);
            check("R3 status word bit", {31'd0, v[c]}, {31'd0, VECS[i].exp_st});
            check("R9 masked irq low", {31'd0, irq[c]}, 32'd0);
        end

        // R11: ch1 untouched by later entries on ch2/ch3
        apb_rd(ad(1, R_CNT), v); check("R11 ch1 count kept", v, 32'd87);

        // R6: reload on a running channel
        apb_wr(ad(1, R_LOAD), 32'd50);
        apb_wr(ad(1, R_EN), 32'd1);
        repeat (5) @(negedge pclk);
        apb_wr(ad(1, R_RLD), 32'h1234);
        apb_rd(ad(1, R_CNT), v); check("R6 reload while running", v, 32'd48);
        apb_wr(ad(1, R_EN), 32'd0);
        apb_rd(ad(1, R_RLD), v); check("R6 reload reads zero", v, 32'd0);

        // R8: busy visible right after an accepted clear on ch2
        apb_wr(ad(2, R_CLR), 32'd1);
        apb_rd(ad(2, R_CLR), v); check("R8 busy after clear", v, 32'd2);
        repeat (6) @(negedge pclk);
        apb_rd(ad(2, R_CLR), v); check("R8 busy ended", v, 32'd0);

        // R8: timeout inside the guard interval, second clear dropped (ch3)
        apb_wr(ad(3, R_LOAD), 32'd4);
        apb_wr(ad(3, R_RLD), 32'd0);
        apb_wr(ad(3, R_EN), 32'd1);
        apb_wr(ad(3, R_CLR), 32'd1);
        apb_wr(ad(3, R_CLR), 32'd1);
        apb_rd(ad(3, R_CLR), v); check("R8 clear ignored while busy", v, 32'd1);
        apb_rd(ad(3, R_CNT), v); check("R4 single stays at zero", v, 32'd0);

        // R9: mask gates the interrupt line
        apb_wr(ad(3, R_MASK), 32'd0);
        check("R9 unmasked irq", {28'd0, irq}, 32'h8);
        apb_wr(ad(3, R_MASK), 32'd1);
        check("R9 masked again", {28'd0, irq}, 32'h0);

        // R7: write of 0 has no effect, write of 1 clears
        apb_wr(ad(0, R_CLR), 32'd0);
        apb_rd(ad(0, R_CLR), v); check("R7 zero write ignored", v, 32'd1);
        apb_wr(ad(0, R_CLR), 32'd1);
        repeat (6) @(negedge pclk);
        apb_rd(ad(0, R_CLR), v); check("R7 status cleared", v, 32'd0);
        apb_rd(ad(0, R_STAT), v); check("R10 status word", v, 32'h8);

        // R10: foreign windows and empty offsets
        apb_rd(ad(1, R_STAT), v); check("R10 ch1 offset 0", v, 32'd0);
        apb_rd(ad(3, R_STAT), v); check("R10 ch3 offset 0", v, 32'd0);
        apb_rd(ad(0, 6'h0C), v);  check("R10 empty offset", v, 32'd0);
        apb_rd(ad(2, 6'h3C), v);  check("R10 top offset", v, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule